// File: doc/BRIEF.md
# Stereo Gain Register with Zero-Cross Commit

This block holds the gain and mute settings for a left/right output pair in two levels. Software-side writes land in a per-channel shadow register and do not reach the active gain. The active gain changes only when an update request is issued. One request moves both channels' shadow values forward, so a left/right pair can change its gain together.

When zero-cross mode is on, an update request does not commit at once. Each channel holds its pending value until that channel's own sample stream crosses zero, which keeps steps in gain from producing audible clicks. A timeout counter can be switched on separately. It runs on an external slow tick and forces out any value still pending after a set number of ticks with no crossing. The active gain and mute values are registered outputs that feed the analogue gain stage.

Top module: `stereo_gain_commit`

## Requirements
- R1: During and after a synchronous reset, both channels' active and shadow settings are gain `RST_GAIN` with mute set (1), and nothing is pending.
- R2: A write to a channel's shadow register (wr_l or wr_r with wr_gain and wr_mute) without a request leaves that channel's active gain and mute unchanged.
- R3: With zc_en low, a request (commit_wr high) loads both channels' shadow values into the active registers at the sampling clock edge, so they appear one cycle after the request. A shadow write in the same cycle as the request is included.
- R4: With zc_en high, a request makes both channels pending. A pending channel commits at a later clock edge with smp_vld high where its sample is zero, or where the sign bit (MSB) of its sample differs from that of the channel's previous valid sample.
- R5: Each channel commits on its own crossing. A crossing on one channel does not commit the other channel.
- R6: With to_en high, the TO_LIMIT-th to_tick after the latest request commits every channel that is still pending.
- R7: With to_en low, to_tick pulses have no effect and a pending value stays pending.
- R8: A new request while a value is pending replaces the pending values with the current shadow values and restarts the timeout count from zero.
- R9: A request that arrives in the same cycle as a crossing wins. That crossing commits neither the old nor the new pending value.
- R10: Clearing zc_en while a channel is pending commits its pending value at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_l | input | 1 | Write strobe for the left shadow register |
| wr_r | input | 1 | Write strobe for the right shadow register |
| wr_gain | input | GAIN_W | Gain value for a shadow write |
| wr_mute | input | 1 | Mute value for a shadow write |
| commit_wr | input | 1 | Update request (update bit written as 1) |
| zc_en | input | 1 | Defer commits to zero crossings |
| to_en | input | 1 | Enable for the timeout tick |
| to_tick | input | 1 | Slow timeout tick, one cycle wide |
| smp_vld | input | 1 | Sample valid for both channels |
| samp_l | input | SAMP_W | Left signed sample |
| samp_r | input | SAMP_W | Right signed sample |
| act_gain_l | output | GAIN_W | Active left gain |
| act_mute_l | output | 1 | Active left mute |
| act_gain_r | output | GAIN_W | Active right gain |
| act_mute_r | output | 1 | Active right mute |

## Verification
Two events can fall in the same clock cycle here: a fresh update request and a zero crossing on a channel that is already pending. The bench first leaves a value pending on the left channel. It then drives a request and a sign-changing left sample in the same cycle, and expects the active gain to keep its older committed value, not the stale pending one or the new one. Zero-cross detection is swept over every pair of previous and current 4-bit samples, and every gain pair is swept through the direct path.

// File: rtl/stereo_gain_pkg.sv
package stereo_gain_pkg;
  localparam int NUM_CH = 2;

  typedef enum int {
    CH_LEFT  = 0,
    CH_RIGHT = 1
  } chan_e;
endpackage

// File: rtl/zc_sense.sv
module zc_sense #(
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [SAMP_W-1:0] samp,
  output logic              hit
);
  localparam int MSB = SAMP_W - 1;

  logic prev_neg;
  logic have_prev;

  // A crossing is an exact zero, or a sign change against the last valid sample
  always_comb begin
    hit = 1'b0;
    if (smp_vld) begin
      if (samp == '0)
        hit = 1'b1;
      else if (have_prev && (samp[MSB] != prev_neg))
        hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_neg  <= 1'b0;
      have_prev <= 1'b0;
    end else if (smp_vld) begin
      prev_neg  <= samp[MSB];
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/gain_slot.sv
module gain_slot #(
  parameter int              CFG_W   = 7,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_cfg,
  input  logic             req,
  input  logic             zc_en,
  input  logic             zc_hit,
  input  logic             to_fire,
  output logic [CFG_W-1:0] act_cfg,
  output logic             pending
);
  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] shadow_nx;
  logic [CFG_W-1:0] pend_q;

  // A same-cycle write is visible to a request in that cycle
  assign shadow_nx = wr_en ? wr_cfg : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RST_CFG;
      pend_q   <= RST_CFG;
      act_cfg  <= RST_CFG;
      pending  <= 1'b0;
    end else begin
      shadow_q <= shadow_nx;
      if (req) begin
        if (zc_en) begin
          pend_q  <= shadow_nx;
          pending <= 1'b1;
        end else begin
          act_cfg <= shadow_nx;
          pending <= 1'b0;
        end
      end else if (pending && (!zc_en || zc_hit || to_fire)) begin
        act_cfg <= pend_q;
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/commit_timer.sv
module commit_timer #(
  parameter int TO_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic any_pend,
  input  logic to_en,
  input  logic to_tick,
  output logic fire
);
  localparam int CNT_W = $clog2(TO_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = any_pend && to_en && to_tick && !req;
  assign fire = step && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || req || !any_pend)
      cnt_q <= '0;
    else if (step)
      cnt_q <= fire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/stereo_gain_commit.sv
module stereo_gain_commit
  import stereo_gain_pkg::*;
#(
  parameter int GAIN_W   = 6,
  parameter int SAMP_W   = 16,
  parameter int TO_LIMIT = 1024,
  parameter int RST_GAIN = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_l,
  input  logic              wr_r,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic              wr_mute,
  input  logic              commit_wr,
  input  logic              zc_en,
  input  logic              to_en,
  input  logic              to_tick,
  input  logic              smp_vld,
  input  logic [SAMP_W-1:0] samp_l,
  input  logic [SAMP_W-1:0] samp_r,
  output logic [GAIN_W-1:0] act_gain_l,
  output logic              act_mute_l,
  output logic [GAIN_W-1:0] act_gain_r,
  output logic              act_mute_r
);
  localparam int CFG_W = GAIN_W + 1;
  localparam logic [CFG_W-1:0] RST_CFG = {1'b1, GAIN_W'(RST_GAIN)};

  logic [NUM_CH-1:0] wr_v;
  logic [NUM_CH-1:0] hit_v;
  logic [NUM_CH-1:0] pend_v;
  logic [SAMP_W-1:0] samp_v [NUM_CH];
  logic [CFG_W-1:0]  act_v  [NUM_CH];
  logic [CFG_W-1:0]  wr_cfg;
  logic              to_fire;

  assign wr_cfg            = {wr_mute, wr_gain};
  assign wr_v[CH_LEFT]     = wr_l;
  assign wr_v[CH_RIGHT]    = wr_r;
  assign samp_v[CH_LEFT]   = samp_l;
  assign samp_v[CH_RIGHT]  = samp_r;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    zc_sense #(
      .SAMP_W (SAMP_W)
    ) u_zc (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .samp    (samp_v[ch]),
      .hit     (hit_v[ch])
    );

    gain_slot #(
      .CFG_W   (CFG_W),
      .RST_CFG (RST_CFG)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_v[ch]),
      .wr_cfg  (wr_cfg),
      .req     (commit_wr),
      .zc_en   (zc_en),
      .zc_hit  (hit_v[ch]),
      .to_fire (to_fire),
      .act_cfg (act_v[ch]),
      .pending (pend_v[ch])
    );
  end

  commit_timer #(
    .TO_LIMIT (TO_LIMIT)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .req      (commit_wr),
    .any_pend (|pend_v),
    .to_en    (to_en),
    .to_tick  (to_tick),
    .fire     (to_fire)
  );

  assign {act_mute_l, act_gain_l} = act_v[CH_LEFT];
  assign {act_mute_r, act_gain_r} = act_v[CH_RIGHT];
endmodule

// File: rtl/stereo_gain_commit_chk.sv
module stereo_gain_commit_chk #(
  parameter int CFG_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             commit_wr,
  input logic             zc_en,
  input logic             to_en,
  input logic [CFG_W-1:0] act_l,
  input logic [CFG_W-1:0] act_r,
  input logic [1:0]       pend_v,
  input logic [1:0]       hit_v,
  input logic             to_fire
);
  AST_HOLD_IDLE_L: assert property (@(posedge clk) disable iff (rst)
    (!commit_wr && !pend_v[0]) |=> $stable(act_l)); // R2
  AST_HOLD_IDLE_R: assert property (@(posedge clk) disable iff (rst)
    (!commit_wr && !pend_v[1]) |=> $stable(act_r)); // R2
  AST_DIRECT_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (commit_wr && !zc_en) |=> (pend_v == 2'b00)); // R3
  AST_DEFER_BOTH: assert property (@(posedge clk) disable iff (rst)
    (commit_wr && zc_en) |=> (pend_v == 2'b11)); // R4
  AST_FALL_CAUSE_L: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_v[0]) |-> $past(!zc_en || hit_v[0] || to_fire)); // R5
  AST_FALL_CAUSE_R: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_v[1]) |-> $past(!zc_en || hit_v[1] || to_fire)); // R5
  AST_NO_TICK_FIRE: assert property (@(posedge clk) disable iff (rst)
    !to_en |-> !to_fire); // R7
  AST_REQ_OVER_HIT: assert property (@(posedge clk) disable iff (rst)
    (commit_wr && zc_en && hit_v[0]) |=> (pend_v[0] && $stable(act_l))); // R9
  AST_ZC_OFF_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (pend_v[0] && !zc_en && !commit_wr) |=> !pend_v[0]); // R10
endmodule

bind stereo_gain_commit stereo_gain_commit_chk #(
  .CFG_W (CFG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .commit_wr (commit_wr),
  .zc_en     (zc_en),
  .to_en     (to_en),
  .act_l     (act_v[0]),
  .act_r     (act_v[1]),
  .pend_v    (pend_v),
  .hit_v     (hit_v),
  .to_fire   (to_fire)
);

// File: tb/stereo_gain_commit_tb.sv
`timescale 1ns/1ps
module stereo_gain_commit_tb;
  localparam int GW = 4;
  localparam int SW = 4;
  localparam int TL = 4;
  localparam int CW = GW + 1;
  localparam logic [CW-1:0] RST_EXP = {1'b1, {GW{1'b0}}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_l = 0, wr_r = 0, wr_mute = 0, commit_wr = 0;
  logic [GW-1:0] wr_gain = '0;
  logic          zc_en = 0, to_en = 0, to_tick = 0, smp_vld = 0;
  logic [SW-1:0] samp_l = '0, samp_r = '0;
  logic [GW-1:0] act_gain_l, act_gain_r;
  logic          act_mute_l, act_mute_r;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  stereo_gain_commit #(
    .GAIN_W (GW), .SAMP_W (SW), .TO_LIMIT (TL), .RST_GAIN (0)
  ) u_dut (
    .clk (clk), .rst (rst), .wr_l (wr_l), .wr_r (wr_r),
    .wr_gain (wr_gain), .wr_mute (wr_mute), .commit_wr (commit_wr),
    .zc_en (zc_en), .to_en (to_en), .to_tick (to_tick),
    .smp_vld (smp_vld), .samp_l (samp_l), .samp_r (samp_r),
    .act_gain_l (act_gain_l), .act_mute_l (act_mute_l),
    .act_gain_r (act_gain_r), .act_mute_r (act_mute_r)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_l(input logic [CW-1:0] c);
    wr_l = 1; {wr_mute, wr_gain} = c; tick(); wr_l = 0;
  endtask

  task automatic write_r(input logic [CW-1:0] c);
    wr_r = 1; {wr_mute, wr_gain} = c; tick(); wr_r = 0;
  endtask

  task automatic commit();
    commit_wr = 1; tick(); commit_wr = 0;
  endtask

  task automatic sample(input int l, input int r);
    smp_vld = 1; samp_l = SW'(l); samp_r = SW'(r); tick(); smp_vld = 0;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      to_tick = 1; tick(); to_tick = 0;
    end
  endtask

  function automatic logic [CW-1:0] act_l();
    return {act_mute_l, act_gain_l};
  endfunction

  function automatic logic [CW-1:0] act_r();
    return {act_mute_r, act_gain_r};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [CW-1:0] pl, pr, cl, cr, v, old;
    tick(); tick();
    check("R1 reset left", act_l(), RST_EXP);
    check("R1 reset right", act_r(), RST_EXP);
    tick();
    rst = 0;
    tick();
    check("R1 after reset left", act_l(), RST_EXP);

    // R2 / R3: every gain pair through the direct path
    pl = RST_EXP; pr = RST_EXP;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        cl = {a[0], GW'(a)};
        cr = {b[1], GW'(b)};
        write_l(cl);
        write_r(cr);
        check("R2 shadow only left", act_l(), pl);
        check("R2 shadow only right", act_r(), pr);
        commit();
        check("R3 direct left", act_l(), cl);
        check("R3 direct right", act_r(), cr);
        pl = cl; pr = cr;
      end
    end

    // R3: write and request in one cycle
    wr_l = 1; {wr_mute, wr_gain} = 5'h0A; commit_wr = 1;
    tick();
    wr_l = 0; commit_wr = 0;
    check("R3 same-cycle write left", act_l(), 5'h0A);
    check("R3 same-cycle write right", act_r(), pr);

    // R4 / R5: deferred commit, independent channels
    zc_en = 1;
    sample(1, 1);
    write_l(5'h13);
    write_r(5'h05);
    commit();
    check("R4 held left", act_l(), 5'h0A);
    sample(2, 3);
    check("R4 no crossing left", act_l(), 5'h0A);
    check("R4 no crossing right", act_r(), pr);
    sample(-1, 3);
    check("R4 sign change left", act_l(), 5'h13);
    check("R5 right not committed", act_r(), pr);
    sample(-1, 0);
    check("R5 zero sample right", act_r(), 5'h05);

    // R4: all previous/current sample pairs on the left channel
    old = 5'h13;
    v = 5'h00;
    for (int p = -8; p < 8; p++) begin
      for (int c = -8; c < 8; c++) begin
        zc_en = 0; tick(); zc_en = 1;
        sample(p, 1);
        v = v + 1'b1;
        if (v == old) v = v + 1'b1;
        write_l(v);
        commit();
        sample(c, 1);
        if (c == 0 || ((p < 0) != (c < 0))) begin
          check("R4 crossing sweep", act_l(), v);
        end else begin
          check("R4 no-crossing sweep", act_l(), old);
        end
        old = v;
      end
    end
    zc_en = 0; tick(); zc_en = 1;

    // R6: timeout commits all pending channels
    to_en = 1;
    sample(1, 1);
    write_l(5'h07);
    write_r(5'h0E);
    commit();
    pulse_ticks(TL - 1);
    check("R6 before limit left", act_l(), old);
    check("R6 before limit right", act_r(), 5'h05);
    pulse_ticks(1);
    check("R6 timeout left", act_l(), 5'h07);
    check("R6 timeout right", act_r(), 5'h0E);

    // R8: replacement restarts the count
    write_l(5'h02);
    commit();
    pulse_ticks(TL - 1);
    write_l(5'h1B);
    commit();
    pulse_ticks(TL - 1);
    check("R8 restarted count", act_l(), 5'h07);
    pulse_ticks(1);
    check("R8 replaced value", act_l(), 5'h1B);

    // R7: ticks ignored without the enable
    to_en = 0;
    write_l(5'h09);
    commit();
    pulse_ticks(3 * TL);
    check("R7 ticks ignored", act_l(), 5'h1B);

    // R9: request and crossing together
    write_l(5'h16);
    commit_wr = 1; smp_vld = 1; samp_l = SW'(-1); samp_r = SW'(1);
    tick();
    commit_wr = 0; smp_vld = 0;
    check("R9 request beats crossing", act_l(), 5'h1B);

    // R10: leaving zero-cross mode flushes
    zc_en = 0;
    tick();
    check("R10 flush left", act_l(), 5'h16);
    check("R10 flush right", act_r(), 5'h0E);

    tick();
    finish_run();
  end
endmodule